// File: doc/BRIEF.md
# Configurable GPIO Port Controller

A bank of general-purpose pins, eight by default, each governed by its own 8-bit configuration register. The register picks the pin's direction, whether the signal is inverted and, for outputs, whether the pad is driven push-pull or emulates an open-drain driver by gating its output enable. A function-select field hands the pin either to a plain peripheral signal or to an either-edge interrupt detector instead of plain GPIO.

Software reaches the bank through a simple synchronous register bus. A write takes effect on the clock edge, and reads are combinational. There is one shared data register, one interrupt status register and one configuration register per pin. Pad inputs are resynchronised by two flops before anything looks at them. On the pad side each pin has an output value, an output enable and an input. The peripheral side gets the alternate output source per pin and receives the conditioned input.

Top module: `gpio_bank`

## Requirements
- R1: After reset every configuration register reads 0x01, the data register holds 0, no pad output enable is asserted and the interrupt output is low.
- R2: Addresses are 0 for data, 1 for interrupt status and 2+i for the configuration of pin i. Configuration bits 6:4 always read 0 and ignore writes. Bits 7, 3:2, 1 and 0 store what was written.
- R3: Configuration bit 0 = 1 makes the pin an input, with its output enable deasserted and pad output 0. Bit 0 = 0 with bit 7 = 0 gives a push-pull output, with the output enable asserted and the pad output equal to the effective output value.
- R4: With configuration bit 1 = 1 the pad output of an output pin is the inverse of its source value. With bit 1 = 0 it equals the source value.
- R5: Configuration bit 1 = 1 inverts the synchronised pad input. This applies to the data-register readback of input pins and to the per-pin peripheral input.
- R6: With bit 0 = 0 and bit 7 = 1 the pad output is held at 0. The output enable is asserted exactly when the effective output value is 0. Bit 7 has no effect on an input pin.
- R7: Function field bits 3:2 = 1 makes the peripheral's alternate output bit the output source, with polarity still applied. Values 0, 2 and 3 use the data register bit as the source.
- R8: Reading the data register returns the written bit for output pins. A write to an input pin's bit is stored without changing its pad, and the stored value appears on the pad once the pin becomes an output.
- R9: A pad input change appears in the data readback after two rising clock edges and not after one.
- R10: For a pin whose function field is 2, any change of the synchronised raw input, rising or falling, sets that pin's sticky status bit regardless of bit 1. Pins with other function values never set status.
- R11: Writing 1 to a bit of the status register clears it and writing 0 leaves it. The interrupt output is the OR of all status bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pad_in | input | NPINS | Raw pad inputs, asynchronous |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables, 1 = drive |
| alt_out | input | NPINS | Peripheral output source per pin |
| periph_in | output | NPINS | Synchronised, polarity-applied input to the peripheral |
| irq | output | 1 | OR of the interrupt status bits |

## Verification
The bench targets open-drain emulation. A design that drove the pad high, or that left the enable on for a logical 1, shows up as a wrong pad_out or pad_oe. Polarity is exercised on both directions and on the alternate path. A design that inverted only outputs, or that let polarity leak into the edge detector, either misreads inputs or misses or mis-flags edges. The synchroniser latency is probed one edge early to catch a missing or extra flop. Partial write-one-to-clear on the status register exposes a design that clears everything on any write or lets irq drop while bits remain set.

// File: rtl/gpio_pkg.sv
// Shared types and constants of the GPIO bank.
// Assumes an 8-bit register bus; configuration bit positions are fixed.
package gpio_pkg;
    localparam int BUS_W = 8;

    typedef enum logic [1:0] {
        FN_GPIO = 2'd0,
        FN_ALT  = 2'd1,
        FN_EDGE = 2'd2,
        FN_SPARE = 2'd3
    } pin_fn_e;

    // bit7 open-drain, 6:4 reserved, 3:2 function, 1 polarity, 0 input
    typedef struct packed {
        logic     od;
        logic [2:0] rsvd;
        pin_fn_e  fn;
        logic     inv;
        logic     is_in;
    } pin_cfg_t;

    localparam logic [BUS_W-1:0] CFG_RESET = 8'h01;
    localparam logic [BUS_W-1:0] CFG_WMASK = 8'h8F;
    localparam int OFS_DATA = 0;
    localparam int OFS_STAT = 1;
    localparam int OFS_CFG0 = 2;
endpackage

// File: rtl/gpio_sync.sv
// Two-flop resynchroniser for a vector of asynchronous pad inputs.
// Assumes each bit is independent; bits may settle on different cycles.
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;

    // Shift the raw inputs through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/gpio_pin_cell.sv
// Combinational pad and readback logic for one pin.
// Assumes the configuration is already masked; the sync input is clean.
module gpio_pin_cell
    import gpio_pkg::*;
(
    input  pin_cfg_t cfg,
    input  logic     data_bit,
    input  logic     alt_bit,
    input  logic     sync_bit,
    output logic     pad_out,
    output logic     pad_oe,
    output logic     rd_bit,
    output logic     periph_bit
);
    logic src;
    logic eff;

    // Pick the output source and apply polarity.
    always_comb begin
        src = (cfg.fn == FN_ALT) ? alt_bit : data_bit;
        eff = src ^ cfg.inv;
    end

    // Drive the pad: input, open-drain or push-pull.
    always_comb begin
        if (cfg.is_in) begin
            pad_out = 1'b0;
            pad_oe  = 1'b0;
        end else if (cfg.od) begin
            pad_out = 1'b0;
            pad_oe  = ~eff;
        end else begin
            pad_out = eff;
            pad_oe  = 1'b1;
        end
    end

    // Readback and peripheral input see the polarity-applied input.
    always_comb begin
        periph_bit = sync_bit ^ cfg.inv;
        rd_bit     = cfg.is_in ? periph_bit : data_bit;
    end
endmodule

// File: rtl/gpio_edge_det.sv
// Either-edge detector with sticky, write-one-to-clear status bits.
// Assumes inputs are synchronised; set takes priority over clear.
module gpio_edge_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_in,
    input  logic [W-1:0] arm,
    input  logic [W-1:0] clr,
    output logic [W-1:0] status
);
    logic [W-1:0] prev;

    // Remember last synchronised level for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= sync_in;
    end

    // Accumulate armed edges, drop bits written with 1.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | (arm & (sync_in ^ prev));
    end
endmodule

// File: rtl/gpio_bank.sv
// GPIO bank: per-pin configuration, shared data register, pad muxing,
// alternate-function routing and either-edge interrupts.
// Assumes NPINS <= 8 and that the address space holds NPINS+2 registers.
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    input  logic [NPINS-1:0]  alt_out,
    output logic [NPINS-1:0]  periph_in,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    pin_cfg_t         cfg_q [NPINS];
    logic [NPINS-1:0] data_q;
    logic [NPINS-1:0] sync_vec;
    logic [NPINS-1:0] rd_vec;
    logic [NPINS-1:0] arm_vec;
    logic [NPINS-1:0] clr_vec;
    logic [NPINS-1:0] status_vec;
    logic [NPINS-1:0] dir_vec;
    logic [NPINS-1:0] od_vec;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (sync_vec)
    );

    // Data register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                          data_q <= '0;
        else if (bus_wr && bus_addr == A_DATA) data_q <= bus_wdata[NPINS-1:0];
    end

    // Status clear mask from a write to the status address.
    always_comb begin
        clr_vec = (bus_wr && bus_addr == A_STAT) ? bus_wdata[NPINS-1:0] : '0;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CFG0 + i);

        // Per-pin configuration register, reserved bits masked.
        always_ff @(posedge clk) begin
            if (!rst_n)                         cfg_q[i] <= pin_cfg_t'(CFG_RESET);
            else if (bus_wr && bus_addr == A_CFG) cfg_q[i] <= pin_cfg_t'(bus_wdata & CFG_WMASK);
        end

        gpio_pin_cell u_cell (
            .cfg        (cfg_q[i]),
            .data_bit   (data_q[i]),
            .alt_bit    (alt_out[i]),
            .sync_bit   (sync_vec[i]),
            .pad_out    (pad_out[i]),
            .pad_oe     (pad_oe[i]),
            .rd_bit     (rd_vec[i]),
            .periph_bit (periph_in[i])
        );

        // Per-pin control flags for the detector and the checker.
        always_comb begin
            arm_vec[i] = (cfg_q[i].fn == FN_EDGE);
            dir_vec[i] = cfg_q[i].is_in;
            od_vec[i]  = cfg_q[i].od;
        end
    end

    gpio_edge_det #(.W(NPINS)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_vec),
        .arm     (arm_vec),
        .clr     (clr_vec),
        .status  (status_vec)
    );

    // Interrupt output.
    always_comb irq = |status_vec;

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_DATA) begin
            bus_rdata[NPINS-1:0] = rd_vec;
        end else if (bus_addr == A_STAT) begin
            bus_rdata[NPINS-1:0] = status_vec;
        end else begin
            for (int i = 0; i < NPINS; i++) begin
                if (bus_addr == ADDR_W'(OFS_CFG0 + i)) bus_rdata = cfg_q[i];
            end
        end
    end
endmodule

// File: rtl/gpio_bank_checker.sv
// Property checker for gpio_bank, attached by bind.
// Assumes it observes the configuration flags and the status register.
module gpio_bank_checker #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] dir_vec,
    input logic [NPINS-1:0] od_vec,
    input logic [NPINS-1:0] status_vec,
    input logic             irq
);
    // Input pins never drive their pad (R3).
    p_input_undriven_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & dir_vec) == '0);

    // Push-pull outputs always drive (R3).
    p_pushpull_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (~dir_vec & ~od_vec & ~pad_oe) == '0);

    // Open-drain outputs never drive high (R6).
    p_od_never_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (~dir_vec & od_vec & pad_out) == '0);

    // Status bits are sticky without a bus write (R11).
    p_status_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ((status_vec & $past(status_vec)) == $past(status_vec)));

    // Interrupt follows the status bits (R11).
    p_irq_is_or_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (status_vec != '0));
endmodule

bind gpio_bank gpio_bank_checker #(.NPINS(NPINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .dir_vec    (dir_vec),
    .od_vec     (od_vec),
    .status_vec (status_vec),
    .irq        (irq)
);

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
// Directed bench for gpio_bank: one task per scenario.
module gpio_bank_bench;
    localparam int N = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out;
    logic [N-1:0]  pad_oe;
    logic [N-1:0]  alt_out = '0;
    logic [N-1:0]  periph_in;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    gpio_bank #(.NPINS(N), .ADDR_W(AW)) u_gpio_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .alt_out(alt_out),
        .periph_in(periph_in), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        bus_addr = AW'(a);
        #1 d = bus_rdata;
    endtask

    task automatic cfg_all(input logic [7:0] v);
        for (int i = 0; i < N; i++) wr(2 + i, v);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int i = 0; i < N; i++) begin
            rd(2 + i, d); check("R1 cfg reset", d, 8'h01);
        end
        rd(0, d); check("R1 data reset", d, 8'h00);
        check("R1 oe reset", pad_oe, 8'h00);
        check("R1 irq reset", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        wr(2, 8'h71); rd(2, d); check("R2 reserved bits", d, 8'h01);
        wr(3, 8'hFF); rd(3, d); check("R2 stored bits", d, 8'h8F);
        wr(3, 8'h01);
    endtask

    task automatic t_direction();
        logic [7:0] d;
        wr(0, 8'hA5); cfg_all(8'h00); ticks(1);
        check("R3 push-pull oe", pad_oe, 8'hFF);
        check("R3 push-pull out", pad_out, 8'hA5);
        rd(0, d); check("R8 output readback", d, 8'hA5);
    endtask

    task automatic t_pol_out();
        cfg_all(8'h02); ticks(1);
        check("R4 inverted out", pad_out, 8'h5A);
    endtask

    task automatic t_open_drain();
        cfg_all(8'h80); ticks(1);
        check("R6 od out low", pad_out, 8'h00);
        check("R6 od oe", pad_oe, 8'h5A);
        cfg_all(8'h81); ticks(1);
        check("R6 od on input", pad_oe, 8'h00);
    endtask

    task automatic t_pol_in();
        logic [7:0] d;
        pad_in = 8'h3C; cfg_all(8'h03); ticks(3);
        rd(0, d); check("R5 inverted readback", d, 8'hC3);
        check("R5 inverted periph", periph_in, 8'hC3);
        cfg_all(8'h01); ticks(1);
        rd(0, d); check("R5 plain readback", d, 8'h3C);
    endtask

    task automatic t_sync();
        logic [7:0] d;
        pad_in = 8'h00; ticks(3);
        pad_in = 8'hFF; ticks(1);
        rd(0, d); check("R9 one edge", d, 8'h00);
        ticks(1);
        rd(0, d); check("R9 two edges", d, 8'hFF);
    endtask

    task automatic t_input_write();
        wr(0, 8'h0F); ticks(1);
        check("R8 input write no pad", pad_oe, 8'h00);
        cfg_all(8'h00); ticks(1);
        check("R8 stored value", pad_out, 8'h0F);
    endtask

    task automatic t_alt();
        alt_out = 8'h55; cfg_all(8'h04); ticks(1);
        check("R7 alt out", pad_out, 8'h55);
        cfg_all(8'h06); ticks(1);
        check("R7 alt inverted", pad_out, 8'hAA);
        cfg_all(8'h0C); ticks(1);
        check("R7 spare uses data", pad_out, 8'h0F);
        pad_in = 8'h96; cfg_all(8'h07); ticks(3);
        check("R7 periph input", periph_in, 8'h69);
    endtask

    task automatic t_edge();
        logic [7:0] d;
        pad_in = 8'h00; cfg_all(8'h01); ticks(3);
        wr(2, 8'h09); wr(3, 8'h0B); ticks(3);
        wr(1, 8'hFF); ticks(1);
        rd(1, d); check("R10 clean start", d, 8'h00);
        pad_in = 8'h07; ticks(4);
        rd(1, d); check("R10 rise, polarity ignored, gpio silent", d, 8'h03);
        wr(1, 8'hFF); pad_in = 8'h06; ticks(4);
        rd(1, d); check("R10 fall", d, 8'h01);
    endtask

    task automatic t_w1c();
        logic [7:0] d;
        pad_in = 8'h05; ticks(4);
        rd(1, d); check("R11 both set", d, 8'h03);
        wr(1, 8'h01); ticks(1);
        rd(1, d); check("R11 partial clear", d, 8'h02);
        check("R11 irq held", {7'd0, irq}, 8'h01);
        wr(1, 8'h02); ticks(1);
        check("R11 irq low", {7'd0, irq}, 8'h00);
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        ticks(3);
        rst_n = 1'b1;
        ticks(1);
        t_reset();
        t_reserved();
        t_direction();
        t_pol_out();
        t_open_drain();
        t_pol_in();
        t_sync();
        t_input_write();
        t_alt();
        t_edge();
        t_w1c();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule